// File: doc/BRIEF.md
# Windowed Max-Select Fan PWM Generator

This block drives a fan's power switch with a slow pulse-width modulated signal. Two 8-bit control codes come in, for example from two temperature sensing paths. The larger of the two sets the fan speed. Only a window of the code range is used. Codes at or below the lower edge of the window give no drive. Codes at or above the upper edge give continuous drive. Codes in between map linearly onto the 256 duty steps.

The period is built from 256 slots, and each slot lasts `SLOT_CYC` clocks. With the default setting and a 50 MHz clock, the period is about 30 Hz. The duty value and a force-high request are both captured only at the start of a period, so the drive never changes shape in mid-period. A one-clock tick marks the last cycle of every period, which lets a surrounding sequencer count periods. When the enable input is low, the output stays off and the period timer is held at its start.

Top module: `fan_pwm_gen`

## Requirements
- R1: While reset is active and after it is released with enable low, `pwm_o` and `tick_o` are both low.
- R2: The duty is taken from the larger of `code_a_i` and `code_b_i`. Swapping which input carries the larger code gives the same result.
- R3: For a controlling code c with LO_CODE < c < LO_CODE+SPAN_CODE, the high time in one period is SLOT_CYC × floor((c − LO_CODE) × 256 / SPAN_CODE) clocks. With the defaults 77/102, code 128 gives half the period.
- R4: A controlling code of LO_CODE+SPAN_CODE (179) or more keeps `pwm_o` high for every cycle of the period.
- R5: A controlling code of LO_CODE (77) or less keeps `pwm_o` low for every cycle of the period, with no short pulse.
- R6: The codes are sampled only on the clock edge that starts a period. A change during the period has no effect until the next period. A change in the last cycle of a period applies to the period that follows.
- R7: A force-high request sampled at the start of a period holds `pwm_o` high for that entire period. A request raised in mid-period takes effect only from the next period.
- R8: While `en_i` is low, `pwm_o` is low, no tick occurs, and the period timer is held at slot 0. After `en_i` rises, the first period starts at slot 0 and its tick falls exactly 256×SLOT_CYC − 1 cycles after the rise.
- R9: `tick_o` is high for exactly one clock, in the last cycle of each period.
- R10: A period lasts 256 × SLOT_CYC clocks. Within a period, `pwm_o` is high during the leading slots, from slot 0 up to slot duty−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_a_i | input | CODE_W | First control code |
| code_b_i | input | CODE_W | Second control code |
| en_i | input | 1 | Run enable; low holds the timer at zero and the output off |
| force_i | input | 1 | Request for a full-on period |
| pwm_o | output | 1 | Fan drive signal |
| tick_o | output | 1 | One-clock marker in the last cycle of each period |

## Verification
The risky coincidence is a new code or a force request arriving in the same clock as the period boundary. Two things must happen on that one edge: the timer wraps and the duty register reloads. The bench changes a code, and separately raises the force request, right after sampling the cycle that carries the tick. It then expects the old shape to finish untouched and the very next period to take the new value. It also changes inputs in mid-period and confirms the high-cycle count of the running period does not change. Period counts are taken from the tick position, so a tick that is misplaced by one cycle also fails.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

    localparam int SLOT_W    = 8;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int DUTY_W    = SLOT_W + 1;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [DUTY_W-1:0] duty_t;

    localparam duty_t DUTY_FULL = duty_t'(NUM_SLOTS);

endpackage

// File: rtl/fan_duty_map.sv
module fan_duty_map
    import fan_pwm_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int LO_CODE   = 77,
    parameter int SPAN_CODE = 102
) (
    input  logic [CODE_W-1:0] code_a_i,
    input  logic [CODE_W-1:0] code_b_i,
    output duty_t             duty_o
);

    localparam int PROD_W = CODE_W + SLOT_W + 1;

    logic [CODE_W-1:0] ctrl_w;
    logic [PROD_W-1:0] offs_w;
    logic [PROD_W-1:0] scaled_w;

    // larger of the two codes rules
    assign ctrl_w = (code_a_i >= code_b_i) ? code_a_i : code_b_i;

    always_comb begin
        offs_w   = '0;
        scaled_w = '0;
        if (int'(ctrl_w) <= LO_CODE) begin
            duty_o = '0;
        end else begin
            offs_w = PROD_W'(int'(ctrl_w) - LO_CODE);
            if (int'(offs_w) >= SPAN_CODE) begin
                duty_o = DUTY_FULL;
            end else begin
                scaled_w = (offs_w << SLOT_W) / PROD_W'(SPAN_CODE);
                duty_o   = duty_t'(scaled_w);
            end
        end
    end

endmodule

// File: rtl/fan_slot_timer.sv
module fan_slot_timer
    import fan_pwm_pkg::*;
#(
    parameter int SLOT_CYC = 6510
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  run_i,
    output slot_t slot_o,
    output logic  last_o
);

    localparam int PRE_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_CYC - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        slot_t            slot;
    } tmr_t;

    tmr_t st_d, st_q;
    logic slot_end_w;

    assign slot_end_w = (st_q.pre == PRE_LAST);

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (slot_end_w) begin
            st_d.pre  = '0;
            st_d.slot = st_q.slot + slot_t'(1);
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign slot_o = st_q.slot;
    assign last_o = run_i && slot_end_w && (st_q.slot == slot_t'(NUM_SLOTS - 1));

    AST_IDLE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (st_q.pre == '0 && st_q.slot == '0)); // R8

    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> !last_o); // R9

    AST_SLOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && slot_end_w) |=> (st_q.slot == $past(st_q.slot) + slot_t'(1))); // R10

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
    import fan_pwm_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int SLOT_CYC  = 6510,
    parameter int LO_CODE   = 77,
    parameter int SPAN_CODE = 102
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_a_i,
    input  logic [CODE_W-1:0] code_b_i,
    input  logic              en_i,
    input  logic              force_i,
    output logic              pwm_o,
    output logic              tick_o
);

    typedef struct packed {
        duty_t duty;
        logic  force_on;
    } ctl_t;

    ctl_t  st_d, st_q;
    duty_t map_w;
    slot_t slot_w;
    logic  last_w;

    fan_duty_map #(
        .CODE_W    (CODE_W),
        .LO_CODE   (LO_CODE),
        .SPAN_CODE (SPAN_CODE)
    ) u_map (
        .code_a_i (code_a_i),
        .code_b_i (code_b_i),
        .duty_o   (map_w)
    );

    fan_slot_timer #(
        .SLOT_CYC (SLOT_CYC)
    ) u_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (en_i),
        .slot_o (slot_w),
        .last_o (last_w)
    );

    // reload only while idle or on the edge that opens a new period
    always_comb begin
        st_d = st_q;
        if (!en_i || last_w) begin
            st_d.duty     = map_w;
            st_d.force_on = force_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pwm_o  = en_i && (st_q.force_on || ({1'b0, slot_w} < st_q.duty));
    assign tick_o = last_w;

    AST_DUTY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i) && !$past(last_w)) |-> $stable(st_q.duty)); // R6

    AST_FORCE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i) && !$past(last_w)) |-> $stable(st_q.force_on)); // R7

    AST_FULL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && st_q.duty == DUTY_FULL) |-> pwm_o); // R4

    AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !st_q.force_on && st_q.duty == '0) |-> !pwm_o); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (!pwm_o && !tick_o)); // R8

    AST_DUTY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.duty <= DUTY_FULL); // R3

endmodule

// File: tb/fan_pwm_gen_tb.sv
module fan_pwm_gen_tb;

    localparam int SLOT_CYC = 2;
    localparam int PERIOD   = 256 * SLOT_CYC;
    localparam int LO       = 77;
    localparam int SPAN     = 102;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] code_a = '0;
    logic [7:0] code_b = '0;
    logic       en = 1'b0;
    logic       frc = 1'b0;
    logic       pwm;
    logic       tick;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    fan_pwm_gen #(
        .CODE_W    (8),
        .SLOT_CYC  (SLOT_CYC),
        .LO_CODE   (LO),
        .SPAN_CODE (SPAN)
    ) u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .code_a_i (code_a),
        .code_b_i (code_b),
        .en_i     (en),
        .force_i  (frc),
        .pwm_o    (pwm),
        .tick_o   (tick)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, act=%0d exp=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_high(input int a, input int b, input bit f);
        int c, d;
        if (f) return PERIOD;
        c = (a > b) ? a : b;
        if (c <= LO) d = 0;
        else if (c - LO >= SPAN) d = 256;
        else d = ((c - LO) * 256) / SPAN;
        return d * SLOT_CYC;
    endfunction

    // idle one edge to load, then enable; leaves us sampling period index 0
    task automatic start_run(input int a, input int b, input bit f);
        @(negedge clk);
        en = 1'b0; code_a = 8'(a); code_b = 8'(b); frc = f;
        @(negedge clk);
        en = 1'b1;
        #1;
    endtask

    // samples one full period; optionally applies new inputs after sample chg_idx
    task automatic measure(input int chg_idx, input int na, input int nb, input bit nf,
                           output int hi, output int tick_cnt, output int tick_pos);
        hi = 0; tick_cnt = 0; tick_pos = -1;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm) hi++;
            if (tick) begin tick_cnt++; tick_pos = i; end
            if (i == chg_idx) begin code_a = 8'(na); code_b = 8'(nb); frc = nf; end
            @(negedge clk);
            #1;
        end
    endtask

    task automatic expect_period(input string req, input int exp_hi);
        int hi, tc, tp;
        measure(-1, 0, 0, 1'b0, hi, tc, tp);
        check(hi == exp_hi, req, hi, exp_hi);
        check(tc == 1 && tp == PERIOD - 1, {req, " R9 tick"}, tp, PERIOD - 1);
    endtask

    task automatic t_reset();
        #5;
        check(!pwm && !tick, "R1 in reset", {pwm, tick}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!pwm && !tick, "R1 after release", {pwm, tick}, 0);
    endtask

    task automatic t_max_select();
        start_run(128, 90, 1'b0);
        expect_period("R2 a larger", exp_high(128, 90, 0));
        start_run(90, 128, 1'b0);
        expect_period("R2 b larger", exp_high(90, 128, 0));
        start_run(60, 153, 1'b0);
        expect_period("R2 b=153", exp_high(60, 153, 0));
    endtask

    task automatic t_linear();
        start_run(128, 0, 1'b0);
        expect_period("R3 half point", PERIOD / 2);
        start_run(102, 0, 1'b0);
        expect_period("R3 low quarter", exp_high(102, 0, 0));
        start_run(78, 0, 1'b0);
        expect_period("R3 one above edge", exp_high(78, 0, 0));
        start_run(178, 0, 1'b0);
        expect_period("R3 one below top", exp_high(178, 0, 0));
    endtask

    task automatic t_clamps();
        start_run(179, 0, 1'b0);
        expect_period("R4 top edge", PERIOD);
        start_run(0, 255, 1'b0);
        expect_period("R4 full scale", PERIOD);
        start_run(77, 77, 1'b0);
        expect_period("R5 low edge", 0);
        start_run(0, 0, 1'b0);
        expect_period("R5 zero", 0);
    endtask

    task automatic t_latch();
        int hi, tc, tp;
        start_run(128, 0, 1'b0);
        measure(200, 0, 0, 1'b0, hi, tc, tp);
        check(hi == PERIOD / 2, "R6 mid-period drop ignored", hi, PERIOD / 2);
        expect_period("R6 drop applied next", 0);
        start_run(128, 0, 1'b0);
        measure(PERIOD - 1, 179, 0, 1'b0, hi, tc, tp);
        check(hi == PERIOD / 2, "R6 last-cycle change ignored", hi, PERIOD / 2);
        expect_period("R6 last-cycle change applied", PERIOD);
    endtask

    task automatic t_force();
        int hi, tc, tp;
        start_run(0, 0, 1'b0);
        measure(100, 0, 0, 1'b1, hi, tc, tp);
        check(hi == 0, "R7 mid-period force ignored", hi, 0);
        measure(5, 0, 0, 1'b0, hi, tc, tp);
        check(hi == PERIOD, "R7 forced period full", hi, PERIOD);
        expect_period("R7 force released", 0);
        start_run(0, 0, 1'b0);
        measure(PERIOD - 1, 0, 0, 1'b1, hi, tc, tp);
        check(hi == 0, "R7 boundary force ignored now", hi, 0);
        measure(-1, 0, 0, 1'b0, hi, tc, tp);
        check(hi == PERIOD, "R7 boundary force next period", hi, PERIOD);
        frc = 1'b0;
    endtask

    task automatic t_enable();
        int hi, tc, tp;
        start_run(200, 0, 1'b0);
        repeat (37) @(negedge clk);
        en = 1'b0;
        #1;
        hi = 0; tc = 0;
        for (int i = 0; i < PERIOD + 50; i++) begin
            if (pwm) hi++;
            if (tick) tc++;
            @(negedge clk);
            #1;
        end
        check(hi == 0, "R8 idle output low", hi, 0);
        check(tc == 0, "R8 idle no tick", tc, 0);
        code_a = 8'd128;
        @(negedge clk);
        en = 1'b1;
        #1;
        measure(-1, 0, 0, 1'b0, hi, tc, tp);
        check(tp == PERIOD - 1 && tc == 1, "R8 restart aligned R10", tp, PERIOD - 1);
        check(hi == PERIOD / 2, "R8 restart duty", hi, PERIOD / 2);
        en = 1'b0;
    endtask

    task automatic t_shape();
        int first_low;
        start_run(128, 0, 1'b0);
        first_low = -1;
        for (int i = 0; i < PERIOD; i++) begin
            if (!pwm && first_low < 0) first_low = i;
            if (first_low >= 0 && pwm) first_low = -2;
            @(negedge clk);
            #1;
        end
        check(first_low == PERIOD / 2, "R10 leading high block", first_low, PERIOD / 2);
    endtask

    initial begin
        t_reset();
        t_max_select();
        t_linear();
        t_clamps();
        t_latch();
        t_force();
        t_enable();
        t_shape();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule